// File: doc/BRIEF.md
# Flash Code Protection Access Gate

This block decides which debug and programming operations a chip may perform. The decision rests on a protection word that sits at a fixed flash location. After reset is released the gate captures that word, decodes it into one of four protection levels, and only then starts answering requests. A second flash word, checked apart from the level, can switch off sampling of the boot-override pin.

Each requester raises a one-cycle strobe and gets back, one clock later, either a grant on its own output or a pulse on the shared deny output. There are four requesters: the serial debug port, the boot-loader command path (read, sector write, sector erase, full erase), application-driven programming calls, and the application's request to re-enter the boot loader. The flash array, the debug port and the command parser sit outside. A completed full-chip erase can drop a level-1 or level-2 setting back to unprotected. Level 3 cannot be cleared from outside.

Top module: `fcp_gate`

## Requirements
- R1: While reset is high, and for the first two clocks after it falls, `ready_o`, every grant output and `boot_pin_en_o` are low. A request made in that window is answered with a deny pulse. The level comes from `prot_word_i`, captured in the first clock after reset: 0x12345678 gives level 1, 0x87654321 gives level 2, 0x43218765 gives level 3, and any other value gives unprotected. `level_o` encodes these as 1, 2, 3 and 0.
- R2: At the unprotected level every request is granted, including every boot-loader command on any sector.
- R3: A debug port request is granted only at the unprotected level. At levels 1, 2 and 3 it is denied.
- R4: At level 1, a boot-loader sector write (`bl_cmd_i`=1) or sector erase (`bl_cmd_i`=2) is granted when `bl_sector_i` is nonzero and denied when it is zero. Read (`bl_cmd_i`=0) and full erase (`bl_cmd_i`=3) are denied.
- R5: At level 2, full erase (3) and sector write (1) are granted. Sector erase (2) and read (0) are denied.
- R6: At level 3, every boot-loader command is denied and `boot_pin_en_o` is low.
- R7: Once `ready_o` is high, application programming requests and boot-loader re-entry requests are granted at every level.
- R8: When `pin_off_word_i` equals 0xB0070FF0 at capture time, `boot_pin_en_o` stays low at every level. Otherwise it is high whenever `ready_o` is high and the level is not 3.
- R9: A pulse on `erase_done_i` while the level is 1 or 2 sets `level_o` to 0 at the next clock, and the permissions change to match. At level 3 the pulse has no effect.
- R10: Each request strobe is answered in the next cycle by exactly one of two things: its grant output high, or `deny_o` high. The answer lasts one cycle. With no request, no grant and no deny appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_word_i | input | 32 | Protection word read from the fixed flash location |
| pin_off_word_i | input | 32 | Word that disables boot-pin sampling when it holds its magic value |
| erase_done_i | input | 1 | Pulse: a full-chip erase has completed |
| dbg_req_i | input | 1 | Debug port access request strobe |
| bl_req_i | input | 1 | Boot-loader command request strobe |
| bl_cmd_i | input | 2 | Boot-loader command: 0 read, 1 sector write, 2 sector erase, 3 full erase |
| bl_sector_i | input | SECT_W | Target sector of a sector command |
| app_req_i | input | 1 | Application programming call request strobe |
| reinv_req_i | input | 1 | Application request to re-enter the boot loader |
| ready_o | output | 1 | The level has been decoded and the grants are valid |
| level_o | output | 2 | Current protection level, 0 to 3 |
| dbg_grant_o | output | 1 | Debug request granted (one cycle after the request) |
| bl_grant_o | output | 1 | Boot-loader command granted |
| app_grant_o | output | 1 | Application programming call granted |
| reinv_grant_o | output | 1 | Boot-loader re-entry granted |
| boot_pin_en_o | output | 1 | Boot-override pin sampling permitted |
| deny_o | output | 1 | One-cycle pulse for any denied request |

## Verification
The assertions assume that requests come as strobes lasting a single cycle, and that `bl_cmd_i` and `bl_sector_i` are valid whenever `bl_req_i` is high. They also assume that both flash words stay stable from reset until capture. The stimulus drives every input on the falling clock edge and holds each request for exactly one cycle. It changes the two words only while reset is high. It raises `erase_done_i` only when no request is pending, so any change of permission is seen on a later request.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] MAGIC_LVL1    = 32'h1234_5678;
    localparam logic [WORD_W-1:0] MAGIC_LVL2    = 32'h8765_4321;
    localparam logic [WORD_W-1:0] MAGIC_LVL3    = 32'h4321_8765;
    localparam logic [WORD_W-1:0] MAGIC_PIN_OFF = 32'hB007_0FF0;

    // request channel indices
    localparam int unsigned CH_DBG   = 0;
    localparam int unsigned CH_BL    = 1;
    localparam int unsigned CH_APP   = 2;
    localparam int unsigned CH_REINV = 3;
    localparam int unsigned NCH      = 4;

    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,
        LVL_1    = 2'd1,
        LVL_2    = 2'd2,
        LVL_3    = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        BL_READ    = 2'd0,
        BL_SECT_WR = 2'd1,
        BL_SECT_ER = 2'd2,
        BL_FULL_ER = 2'd3
    } blcmd_e;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_DECODE = 2'd1,
        ST_RUN    = 2'd2
    } st_e;

    typedef struct packed {
        lvl_e level;
        logic pin_off;
        logic ready;
    } prot_state_t;

    function automatic lvl_e decode_level(input logic [WORD_W-1:0] w);
        lvl_e l;
        case (w)
            MAGIC_LVL1: l = LVL_1;
            MAGIC_LVL2: l = LVL_2;
            MAGIC_LVL3: l = LVL_3;
            default:    l = LVL_OPEN;
        endcase
        return l;
    endfunction

    function automatic logic bl_allowed(input lvl_e l, input blcmd_e c, input logic sect_zero);
        logic ok;
        case (l)
            LVL_OPEN: ok = 1'b1;
            LVL_1:    ok = ((c == BL_SECT_WR) || (c == BL_SECT_ER)) && !sect_zero;
            LVL_2:    ok = (c == BL_FULL_ER) || (c == BL_SECT_WR);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic clearable(input lvl_e l);
        return (l == LVL_1) || (l == LVL_2);
    endfunction

endpackage

// File: rtl/fcp_loader.sv
module fcp_loader
    import fcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] prot_word_i,
    input  logic [WORD_W-1:0] pin_off_word_i,
    input  logic              erase_done_i,
    output prot_state_t       state_o
);

    st_e               st_q;
    logic [WORD_W-1:0] cap_q;
    logic              pin_off_q;
    lvl_e              level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_LOAD;
            cap_q     <= '0;
            pin_off_q <= 1'b0;
            level_q   <= LVL_OPEN;
        end else begin
            case (st_q)
                ST_LOAD: begin
                    cap_q     <= prot_word_i;
                    pin_off_q <= (pin_off_word_i == MAGIC_PIN_OFF);
                    st_q      <= ST_DECODE;
                end
                ST_DECODE: begin
                    level_q <= decode_level(cap_q);
                    st_q    <= ST_RUN;
                end
                ST_RUN: begin
                    if (erase_done_i && clearable(level_q)) begin
                        level_q <= LVL_OPEN;
                    end
                end
                default: st_q <= ST_LOAD;
            endcase
        end
    end

    always_comb begin
        state_o.level   = level_q;
        state_o.pin_off = pin_off_q;
        state_o.ready   = (st_q == ST_RUN);
    end

    // R9: level 3 never leaves once latched
    a_r9_l3_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && level_q == LVL_3) |=> (level_q == LVL_3));

    // R9: erase completion clears a level-1 or level-2 setting
    a_r9_erase_clears: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && erase_done_i && (level_q == LVL_1 || level_q == LVL_2))
        |=> (level_q == LVL_OPEN));

    // R1: once ready, stays ready until the next reset
    a_r1_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |=> (st_q == ST_RUN));

endmodule

// File: rtl/fcp_policy.sv
module fcp_policy
    import fcp_pkg::*;
#(
    parameter int unsigned SECT_W = 5
) (
    input  prot_state_t       ps_i,
    input  logic [NCH-1:0]    req_i,
    input  logic [1:0]        bl_cmd_i,
    input  logic [SECT_W-1:0] bl_sector_i,
    output logic [NCH-1:0]    allow_o,
    output logic              pin_en_o
);

    logic   sect_zero;
    blcmd_e cmd;

    assign sect_zero = (bl_sector_i == '0);
    assign cmd       = blcmd_e'(bl_cmd_i);
    assign pin_en_o  = ps_i.ready && (ps_i.level != LVL_3) && !ps_i.pin_off;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == CH_DBG) begin : g_dbg
            assign allow_o[g] = ps_i.ready && (ps_i.level == LVL_OPEN);
        end else if (g == CH_BL) begin : g_bl
            assign allow_o[g] = ps_i.ready && bl_allowed(ps_i.level, cmd, sect_zero);
        end else begin : g_always
            assign allow_o[g] = ps_i.ready;
        end
    end

    // R1: nothing is allowed before the level is known
    always_comb begin
        if (!ps_i.ready) begin
            a_r1_no_allow_early: assert (allow_o == '0 && !pin_en_o);
        end
    end

    // R6: the top level blocks every boot-loader command
    always_comb begin
        if (ps_i.level == LVL_3 && req_i[CH_BL]) begin
            a_r6_bl_blocked: assert (!allow_o[CH_BL]);
        end
    end

endmodule

// File: rtl/fcp_grant_reg.sv
module fcp_grant_reg
    import fcp_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] allow_i,
    output logic [NCH-1:0] grant_o,
    output logic           deny_o
);

    logic [NCH-1:0] grant_q;
    logic [NCH-1:0] den_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                grant_q[g] <= 1'b0;
                den_q[g]   <= 1'b0;
            end else begin
                grant_q[g] <= req_i[g] && allow_i[g];
                den_q[g]   <= req_i[g] && !allow_i[g];
            end
        end

        // R10: every request gets an answer in the next cycle
        a_r10_answered: assert property (@(posedge clk) disable iff (rst)
            req_i[g] |=> (grant_q[g] || den_q[g]));

        // R10: no answer without a request
        a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
            !req_i[g] |=> (!grant_q[g] && !den_q[g]));
    end

    assign grant_o = grant_q;
    assign deny_o  = |den_q;

endmodule

// File: rtl/fcp_gate.sv
module fcp_gate
    import fcp_pkg::*;
#(
    parameter int unsigned SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       prot_word_i,
    input  logic [31:0]       pin_off_word_i,
    input  logic              erase_done_i,
    input  logic              dbg_req_i,
    input  logic              bl_req_i,
    input  logic [1:0]        bl_cmd_i,
    input  logic [SECT_W-1:0] bl_sector_i,
    input  logic              app_req_i,
    input  logic              reinv_req_i,
    output logic              ready_o,
    output logic [1:0]        level_o,
    output logic              dbg_grant_o,
    output logic              bl_grant_o,
    output logic              app_grant_o,
    output logic              reinv_grant_o,
    output logic              boot_pin_en_o,
    output logic              deny_o
);

    prot_state_t    ps;
    logic [NCH-1:0] req;
    logic [NCH-1:0] allow;
    logic [NCH-1:0] grant;

    always_comb begin
        req           = '0;
        req[CH_DBG]   = dbg_req_i;
        req[CH_BL]    = bl_req_i;
        req[CH_APP]   = app_req_i;
        req[CH_REINV] = reinv_req_i;
    end

    fcp_loader u_loader (
        .clk            (clk),
        .rst            (rst),
        .prot_word_i    (prot_word_i),
        .pin_off_word_i (pin_off_word_i),
        .erase_done_i   (erase_done_i),
        .state_o        (ps)
    );

    fcp_policy #(.SECT_W(SECT_W)) u_policy (
        .ps_i        (ps),
        .req_i       (req),
        .bl_cmd_i    (bl_cmd_i),
        .bl_sector_i (bl_sector_i),
        .allow_o     (allow),
        .pin_en_o    (boot_pin_en_o)
    );

    fcp_grant_reg u_grant (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .allow_i (allow),
        .grant_o (grant),
        .deny_o  (deny_o)
    );

    assign ready_o       = ps.ready;
    assign level_o       = ps.level;
    assign dbg_grant_o   = grant[CH_DBG];
    assign bl_grant_o    = grant[CH_BL];
    assign app_grant_o   = grant[CH_APP];
    assign reinv_grant_o = grant[CH_REINV];

    // R1: no grant leaves the block before ready
    a_r1_quiet_before_ready: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> !(dbg_grant_o || bl_grant_o || app_grant_o || reinv_grant_o));

    // R3: debug port locked at any protected level
    a_r3_dbg_locked: assert property (@(posedge clk) disable iff (rst)
        (ready_o && dbg_req_i && level_o != 2'd0) |=> (!dbg_grant_o && deny_o));

    // R4: sector 0 is never written or erased at level 1
    a_r4_sector0_guard: assert property (@(posedge clk) disable iff (rst)
        (ready_o && bl_req_i && level_o == 2'd1 && bl_sector_i == '0)
        |=> (!bl_grant_o && deny_o));

    // R6: override pin ignored at level 3
    a_r6_pin_ignored: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'd3) |-> !boot_pin_en_o);

    // R7: application calls always pass once ready
    a_r7_app_always: assert property (@(posedge clk) disable iff (rst)
        (ready_o && app_req_i) |=> app_grant_o);

    // R7: boot-loader re-entry always passes once ready
    a_r7_reinv_always: assert property (@(posedge clk) disable iff (rst)
        (ready_o && reinv_req_i) |=> reinv_grant_o);

endmodule

// File: tb/fcp_gate_tb_top.sv
module fcp_gate_tb_top;

    localparam int unsigned SECT_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       prot_word = 32'h0;
    logic [31:0]       pin_off_word = 32'h0;
    logic              erase_done = 1'b0;
    logic [3:0]        rq = 4'b0;
    logic [1:0]        bl_cmd = 2'd0;
    logic [SECT_W-1:0] bl_sector = '0;
    logic              ready_o, dbg_grant_o, bl_grant_o, app_grant_o, reinv_grant_o;
    logic              boot_pin_en_o, deny_o;
    logic [1:0]        level_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    fcp_gate #(.SECT_W(SECT_W)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .prot_word_i    (prot_word),
        .pin_off_word_i (pin_off_word),
        .erase_done_i   (erase_done),
        .dbg_req_i      (rq[0]),
        .bl_req_i       (rq[1]),
        .bl_cmd_i       (bl_cmd),
        .bl_sector_i    (bl_sector),
        .app_req_i      (rq[2]),
        .reinv_req_i    (rq[3]),
        .ready_o        (ready_o),
        .level_o        (level_o),
        .dbg_grant_o    (dbg_grant_o),
        .bl_grant_o     (bl_grant_o),
        .app_grant_o    (app_grant_o),
        .reinv_grant_o  (reinv_grant_o),
        .boot_pin_en_o  (boot_pin_en_o),
        .deny_o         (deny_o)
    );

    // vector: {level[1:0], cmd[1:0], sector_is_zero, expect_grant}
    localparam logic [5:0] VEC [16] = '{
        {2'd1, 2'd0, 1'b0, 1'b0},
        {2'd1, 2'd1, 1'b0, 1'b1},
        {2'd1, 2'd1, 1'b1, 1'b0},
        {2'd1, 2'd2, 1'b0, 1'b1},
        {2'd1, 2'd2, 1'b1, 1'b0},
        {2'd1, 2'd3, 1'b0, 1'b0},
        {2'd2, 2'd3, 1'b1, 1'b1},
        {2'd2, 2'd1, 1'b1, 1'b1},
        {2'd2, 2'd2, 1'b0, 1'b0},
        {2'd2, 2'd0, 1'b0, 1'b0},
        {2'd3, 2'd1, 1'b0, 1'b0},
        {2'd3, 2'd3, 1'b0, 1'b0},
        {2'd3, 2'd0, 1'b1, 1'b0},
        {2'd0, 2'd0, 1'b0, 1'b1},
        {2'd0, 2'd2, 1'b1, 1'b1},
        {2'd0, 2'd3, 1'b1, 1'b1}
    };

    function automatic logic [31:0] word_for(input logic [1:0] l);
        case (l)
            2'd1:    return 32'h1234_5678;
            2'd2:    return 32'h8765_4321;
            2'd3:    return 32'h4321_8765;
            default: return 32'hDEAD_0001;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] l, input logic [31:0] off);
        @(negedge clk);
        rst = 1'b1;
        prot_word = word_for(l);
        pin_off_word = off;
        rq = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // issue one strobe on channel ch; return its grant and the deny pulse
    task automatic strobe(input int ch, output logic g, output logic d);
        logic [3:0] gv;
        @(negedge clk);
        rq = '0;
        rq[ch] = 1'b1;
        @(negedge clk);
        rq = '0;
        gv = {reinv_grant_o, app_grant_o, bl_grant_o, dbg_grant_o};
        g = gv[ch];
        d = deny_o;
    endtask

    task automatic bl_op(input logic [1:0] cmd, input logic sz, output logic g, output logic d);
        bl_cmd = cmd;
        bl_sector = sz ? '0 : SECT_W'(7);
        strobe(1, g, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL R10 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic g, d;

        // R1: reset state
        @(negedge clk);
        chk("R1 ready in reset", ready_o, 0);
        chk("R1 grants in reset", {dbg_grant_o, bl_grant_o, app_grant_o, reinv_grant_o}, 0);
        chk("R1 pin_en in reset", boot_pin_en_o, 0);

        // R1: request during the load window is denied
        prot_word = word_for(2'd0);
        @(negedge clk);
        rst = 1'b0;
        rq[0] = 1'b1;
        @(negedge clk);
        rq = '0;
        chk("R1 ready after one clock", ready_o, 0);
        chk("R1 early dbg grant", dbg_grant_o, 0);
        chk("R1 early deny", deny_o, 1);
        @(negedge clk);
        chk("R1 ready after two clocks", ready_o, 1);
        chk("R10 deny one cycle", deny_o, 0);

        // table walk: R2 R4 R5 R6
        for (int i = 0; i < 16; i++) begin
            do_reset(VEC[i][5:4], 32'h0);
            chk("R1 level decode", level_o, VEC[i][5:4]);
            bl_op(VEC[i][3:2], VEC[i][1], g, d);
            chk($sformatf("R4/R5/R6/R2 vec %0d grant", i), g, VEC[i][0]);
            chk($sformatf("R10 vec %0d deny", i), d, !VEC[i][0]);
        end

        // R3: debug port by level
        for (int l = 0; l < 4; l++) begin
            do_reset(2'(l), 32'h0);
            strobe(0, g, d);
            chk($sformatf("R3 dbg grant lvl %0d", l), g, (l == 0));
            chk($sformatf("R8 pin_en lvl %0d", l), boot_pin_en_o, (l != 3));
        end

        // R6 R7: level 3 still grants app and re-entry
        do_reset(2'd3, 32'h0);
        chk("R6 pin_en low at lvl3", boot_pin_en_o, 0);
        strobe(2, g, d);
        chk("R7 app grant lvl3", g, 1);
        chk("R7 app no deny", d, 0);
        strobe(3, g, d);
        chk("R7 reinvoke grant lvl3", g, 1);

        // R9: erase done has no effect at level 3
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        chk("R9 lvl3 stays", level_o, 3);
        strobe(0, g, d);
        chk("R9 dbg still denied", g, 0);

        // R9: erase done clears level 2
        do_reset(2'd2, 32'h0);
        chk("R9 lvl2 before", level_o, 2);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        chk("R9 lvl2 cleared", level_o, 0);
        strobe(0, g, d);
        chk("R9 dbg granted after clear", g, 1);

        // R9: erase done clears level 1
        do_reset(2'd1, 32'h0);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        chk("R9 lvl1 cleared", level_o, 0);

        // R8: pin-off word at open level, and a near-miss value
        do_reset(2'd0, 32'hB007_0FF0);
        chk("R8 pin off at open", boot_pin_en_o, 0);
        do_reset(2'd1, 32'hB007_0FF1);
        chk("R8 near-miss keeps pin on", boot_pin_en_o, 1);

        // R10: no request, no answer; several at once
        do_reset(2'd1, 32'h0);
        @(negedge clk);
        chk("R10 idle quiet", {dbg_grant_o, bl_grant_o, app_grant_o, reinv_grant_o, deny_o}, 0);
        bl_cmd = 2'd1;
        bl_sector = '0;
        @(negedge clk);
        rq = 4'b0110;
        @(negedge clk);
        rq = '0;
        chk("R10 mixed app grant", app_grant_o, 1);
        chk("R10 mixed bl grant", bl_grant_o, 0);
        chk("R10 mixed deny", deny_o, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule